// File: doc/BRIEF.md
# Folded single-port memory array

This block models a single-ported random access memory that holds 2^n words of 2^m bits. The words are not kept as a flat list. Each physical row holds 2^k words side by side, so there are 2^(n-k) rows of 2^(m+k) columns. The address is split into two fields. The upper field picks a row through a predecoded wordline decoder. The lower field picks one word from that row through a column multiplexer. On a write, the same column select steers the data into the right column group.

One access happens each clock: a read, or a write when the write enable is high. The read result is registered and appears after the clock edge on which the address was sampled. The one-hot wordline vector is also brought out to a port so that row selection can be observed directly.

With the default parameters there are 128 words of 8 bits. They are folded by 4 into 32 rows of 32 columns, and the 5 row bits are predecoded into two 1-of-4 groups and one 1-of-2 group.

Top module: `fold_mem_array`

## Requirements
- R1: In every cycle, including during reset, exactly one bit of `wl` is high. It is bit number `addr[ADDR_W-1:FOLD_LOG]`, and it follows `addr` in the same cycle.
- R2: When `we` is low at a rising edge, `rd_data` after that edge equals the word most recently written to the address sampled at that edge.
- R3: A write stores `wdata` at the addressed word only. Every other word, including the other words that share its physical row, keeps its contents.
- R4: On a write cycle, `rd_data` after the edge shows the contents of the addressed word from before the write.
- R5: While `rst` is high at an edge, `rd_data` becomes all zeros and writes are ignored. Stored words survive a reset.
- R6: The column select is `addr[FOLD_LOG-1:0]`. Addresses that differ only in those bits are separate words in the same row, each readable independently.
- R7: When `we` is low, `wdata` has no effect on any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address: row field in the upper bits, column select in the lower FOLD_LOG bits |
| we | input | 1 | Write enable for this cycle's access |
| wdata | input | 2^WORD_LOG | Data to write |
| rd_data | output | 2^WORD_LOG | Registered read data |
| wl | output | 2^(ADDR_W-FOLD_LOG) | One-hot wordline vector for the current address |

## Verification
The bench first fills every word with a distinct address-derived value. It then reads the memory back in ascending and in descending order. A wrong row split or a wrong column split maps two addresses onto one word, and these sweeps show it as a mismatch. A targeted pattern writes a single column of one row and then reads its row neighbours. This separates a write that updates only its column group from one that clobbers the whole row. Further cases are a read of a word in the same cycle as its write, writes with the enable low, a reset in the middle of traffic, and a long random mix. All reads are compared each cycle against a flat reference array, and the wordline is checked against the expected one-hot value on every access.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;
  // number of predecode groups: pairs of row bits, a lone top bit forms a 1-of-2 group
  function automatic int unsigned predec_groups(input int unsigned row_bits);
    return (row_bits + 1) / 2;
  endfunction
endpackage

// File: rtl/fold_row_predec.sv
module fold_row_predec
  import fold_mem_pkg::*;
#(
  parameter int unsigned ROW_BITS = 5
) (
  input  logic [ROW_BITS-1:0]      row_addr,
  output logic [(1<<ROW_BITS)-1:0] wl
);
  localparam int unsigned ROWS = 1 << ROW_BITS;
  localparam int unsigned NGRP = predec_groups(ROW_BITS);

  logic [3:0]      pre  [NGRP];
  logic [NGRP-1:0] term [ROWS];

  // predecode each pair of row bits into 1-of-4 hot lines
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (2*g + 1 < ROW_BITS) begin : g_pair
      assign pre[g] = 4'(1) << row_addr[2*g+1 : 2*g];
    end else begin : g_single
      assign pre[g] = {2'b00, row_addr[2*g], ~row_addr[2*g]};
    end
  end

  // each wordline ANDs one line from every group
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar g = 0; g < NGRP; g++) begin : g_term
      localparam logic [1:0] SEL = 2'((r >> (2*g)) & 3);
      assign term[r][g] = pre[g][SEL];
    end
    assign wl[r] = &term[r];
  end
endmodule

// File: rtl/fold_col_steer.sv
module fold_col_steer #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned FOLD_LOG = 2
) (
  input  logic [FOLD_LOG-1:0]              col_sel,
  input  logic [WORD_W-1:0]                wdata,
  input  logic [WORD_W*(1<<FOLD_LOG)-1:0]  rd_row,
  output logic [WORD_W*(1<<FOLD_LOG)-1:0]  col_mask,
  output logic [WORD_W*(1<<FOLD_LOG)-1:0]  col_val,
  output logic [WORD_W-1:0]                rd_word
);
  localparam int unsigned FOLD = 1 << FOLD_LOG;

  // bit j of word c lives at physical column j*FOLD + c
  for (genvar j = 0; j < WORD_W; j++) begin : g_bit
    logic [FOLD-1:0] grp;
    for (genvar c = 0; c < FOLD; c++) begin : g_col
      assign col_mask[j*FOLD + c] = (col_sel == FOLD_LOG'(c));
      assign col_val[j*FOLD + c]  = wdata[j];
      assign grp[c]               = rd_row[j*FOLD + c];
    end
    // one FOLD:1 multiplexer per output bit
    assign rd_word[j] = grp[col_sel];
  end
endmodule

// File: rtl/fold_row_array.sv
module fold_row_array #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32
) (
  input  logic            clk,
  input  logic            we,
  input  logic [ROWS-1:0] wl,
  input  logic [COLS-1:0] col_mask,
  input  logic [COLS-1:0] col_val,
  output logic [COLS-1:0] rd_row
);
  logic [COLS-1:0] rows_q [ROWS];

  // masked row update: only the selected column group changes
  always_ff @(posedge clk) begin
    if (we) begin
      for (int r = 0; r < ROWS; r++) begin
        if (wl[r]) rows_q[r] <= (rows_q[r] & ~col_mask) | (col_val & col_mask);
      end
    end
  end

  // wordline-selected row, OR of gated rows
  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wl[r]) rd_row = rd_row | rows_q[r];
    end
  end
endmodule

// File: rtl/fold_mem_array.sv
module fold_mem_array #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned WORD_LOG = 3,
  parameter int unsigned FOLD_LOG = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               we,
  input  logic [(1<<WORD_LOG)-1:0]           wdata,
  output logic [(1<<WORD_LOG)-1:0]           rd_data,
  output logic [(1<<(ADDR_W-FOLD_LOG))-1:0]  wl
);
  localparam int unsigned WORD_W   = 1 << WORD_LOG;
  localparam int unsigned ROW_BITS = ADDR_W - FOLD_LOG;
  localparam int unsigned ROWS     = 1 << ROW_BITS;
  localparam int unsigned COLS     = WORD_W << FOLD_LOG;

  logic [ROW_BITS-1:0] row_addr;
  logic [FOLD_LOG-1:0] col_sel;
  logic [COLS-1:0]     col_mask, col_val, rd_row;
  logic [WORD_W-1:0]   rd_word;
  logic                wr_en;

  assign row_addr = addr[ADDR_W-1:FOLD_LOG];
  assign col_sel  = addr[FOLD_LOG-1:0];
  assign wr_en    = we & ~rst;

  fold_row_predec #(.ROW_BITS(ROW_BITS)) i_predec (
    .row_addr (row_addr),
    .wl       (wl)
  );

  fold_col_steer #(.WORD_W(WORD_W), .FOLD_LOG(FOLD_LOG)) i_steer (
    .col_sel  (col_sel),
    .wdata    (wdata),
    .rd_row   (rd_row),
    .col_mask (col_mask),
    .col_val  (col_val),
    .rd_word  (rd_word)
  );

  fold_row_array #(.ROWS(ROWS), .COLS(COLS)) i_rows (
    .clk      (clk),
    .we       (wr_en),
    .wl       (wl),
    .col_mask (col_mask),
    .col_val  (col_val),
    .rd_row   (rd_row)
  );

  // registered read port, read-before-write on the same word
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end
endmodule

// File: rtl/fold_mem_chk.sv
module fold_mem_chk #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned WORD_LOG = 3,
  parameter int unsigned FOLD_LOG = 2
) (
  input logic                              clk,
  input logic                              rst,
  input logic [ADDR_W-1:0]                 addr,
  input logic                              we,
  input logic [(1<<WORD_LOG)-1:0]          rd_data,
  input logic [(1<<(ADDR_W-FOLD_LOG))-1:0] wl
);
  // R1
  wl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wl) == 1);

  // R1
  wl_row_chk: assert property (@(posedge clk) disable iff (rst)
    wl[addr[ADDR_W-1:FOLD_LOG]] == 1'b1);

  // R5
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rd_data == '0);

  // R2
  reread_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we) && addr == $past(addr)) |=> $stable(rd_data));
endmodule

bind fold_mem_array fold_mem_chk #(
  .ADDR_W(ADDR_W), .WORD_LOG(WORD_LOG), .FOLD_LOG(FOLD_LOG)
) i_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .rd_data(rd_data), .wl(wl)
);

// File: tb/test_fold_mem_array.sv
module test_fold_mem_array;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned WORD_LOG = 3;
  localparam int unsigned FOLD_LOG = 2;
  localparam int unsigned WORD_W   = 1 << WORD_LOG;
  localparam int unsigned WORDS    = 1 << ADDR_W;
  localparam int unsigned FOLD     = 1 << FOLD_LOG;
  localparam int unsigned ROWS     = 1 << (ADDR_W - FOLD_LOG);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rd_data;
  logic [ROWS-1:0]   wl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WORD_W-1:0] ref_mem [WORDS];
  bit                valid   [WORDS];

  always #5 clk = ~clk;

  fold_mem_array #(.ADDR_W(ADDR_W), .WORD_LOG(WORD_LOG), .FOLD_LOG(FOLD_LOG)) i_fold_mem_array (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rd_data(rd_data), .wl(wl)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access; entered and left just after a falling edge
  task automatic step(input logic [ADDR_W-1:0] a, input bit w, input logic [WORD_W-1:0] d,
                      input bit r, input string tag);
    logic [ROWS-1:0]   exp_wl;
    logic [WORD_W-1:0] exp_rd;
    bit                cmp;
    addr = a; we = w; wdata = d; rst = r;
    #1;
    exp_wl = '0;
    exp_wl[a >> FOLD_LOG] = 1'b1;
    check(wl == exp_wl, "R1 wordline", 64'(wl), 64'(exp_wl));
    @(posedge clk);
    cmp    = r || valid[a];
    exp_rd = r ? '0 : ref_mem[a];
    if (w && !r) begin
      ref_mem[a] = d;
      valid[a]   = 1'b1;
    end
    @(negedge clk);
    if (cmp) check(rd_data == exp_rd, tag, 64'(rd_data), 64'(exp_rd));
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) valid[i] = 1'b0;
    @(negedge clk);
    // reset state
    step(7'd5, 1'b0, '0, 1'b1, "R5 reset read");
    step(7'd9, 1'b1, 8'hAA, 1'b1, "R5 write in reset");
    // fill with address-derived values
    for (int i = 0; i < WORDS; i++) step(ADDR_W'(i), 1'b1, WORD_W'(i*37 + 5), 1'b0, "R4 fill");
    // ascending and descending sweeps
    for (int i = 0; i < WORDS; i++) step(ADDR_W'(i), 1'b0, 8'h3C, 1'b0, "R2 ascend");
    for (int i = WORDS-1; i >= 0; i--) step(ADDR_W'(i), 1'b0, 8'hC3, 1'b0, "R2 descend");
    // single column write, neighbours in the same row untouched
    step(7'd13, 1'b1, 8'hFF, 1'b0, "R4 old value");
    for (int c = 0; c < FOLD; c++) step(ADDR_W'(12 + c), 1'b0, '0, 1'b0, "R3 row neighbours");
    step(7'd13, 1'b1, 8'h00, 1'b0, "R4 old value");
    for (int c = 0; c < FOLD; c++) step(ADDR_W'(12 + c), 1'b0, '0, 1'b0, "R6 columns");
    // enable low with garbage data
    for (int i = 40; i < 48; i++) step(ADDR_W'(i), 1'b0, 8'h5A, 1'b0, "R7 no write");
    for (int i = 40; i < 48; i++) step(ADDR_W'(i), 1'b0, 8'hA5, 1'b0, "R7 read back");
    // repeated write to the same word
    step(7'd100, 1'b1, 8'h11, 1'b0, "R4 back to back");
    step(7'd100, 1'b1, 8'h22, 1'b0, "R4 back to back");
    step(7'd100, 1'b0, 8'h00, 1'b0, "R2 after writes");
    // reset mid-run keeps contents, ignores writes
    step(7'd100, 1'b1, 8'h99, 1'b1, "R5 mid reset");
    step(7'd100, 1'b0, 8'h00, 1'b0, "R5 contents kept");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step(ADDR_W'($urandom), 1'($urandom), WORD_W'($urandom), 1'b0, "R3 random mix");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule